// File: doc/BRIEF.md
# Register-Mapped Down-Counting Timer

This block is one down-counter behind eight word-wide registers. Software can load the count at once, or it can leave a separate reload value for the count to pick up later. It chooses a clock divider of 1, 16 or 256. It sets the count width to 16 or 32 bits. It picks one of three ways to handle the count reaching zero: wrap to all-ones (free-running), reload (periodic), or stop (one-shot). A reaching-zero event sets a raw interrupt flag. Software clears that flag by writing any value to a clear register. The interrupt pin shows the flag gated by an enable bit.

The register port is plain. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from `addr` while `rd_en` is high, and is zero otherwise. There is no back-pressure, because every access completes in the cycle it is presented. A timer bank is built by placing several copies side by side, one per address window of eight words.

Top module: `regtimer_top`

## Requirements
- R1: After reset the control register reads 0, the reload value reads 0, the current count reads 0x0000FFFF and `irq` is low.
- R2: A write to word 0 sets the reload value and, on the same edge, the count (masked to the active width). A write to word 6 changes only the reload value. Both words read back the reload value.
- R3: Control bits 3:2 select the divider: 00 divides by 1, 01 by 16, and 10 or 11 by 256. The count moves only on a divider tick. Ticks need control bit 7 set. A write to word 0 or word 2 restarts the divider, so the first tick comes that many edges after the write edge. While bit 7 is clear the count holds.
- R4: With control bit 1 clear, only the low 16 bits count and wrap, and word 1 reads the upper 16 bits as zero. With bit 1 set, all 32 bits count.
- R5: With control bits 6 and 0 both clear (free-running), a tick at count zero loads all-ones for the active width.
- R6: With bit 6 set and bit 0 clear (periodic), a tick at count zero loads the reload value.
- R7: With bit 0 set (one-shot, whatever bit 6 is), a tick at count zero keeps the count at zero. No further event occurs until the count is loaded again.
- R8: A tick that moves the count from 1 to 0 sets the raw flag. A write to word 3 clears it, except when an event occurs on the same edge; the event wins. Word 4 reads the raw flag in bit 0.
- R9: Word 5 and `irq` show the raw flag ANDed with control bit 5.
- R10: Control bit 4 always reads 0. Words 3 and 7 read 0. Writes to words 1 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word offset of the register accessed |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational, zero while `rd_en` is low |
| irq | output | 1 | Level interrupt, masked raw flag |

## Verification
Read data is due in the same cycle that `addr` is presented. A register write shows on the reads right after the edge that captures it. A count step lands on the edge that carries a divider tick. The raw flag, and so `irq`, rises on the edge where the count moves from 1 to 0, with no further delay. The bench changes inputs one nanosecond after each falling edge and compares every output at the falling edge. At that point its behavioural model has taken the same rising edge as the design. This keeps each comparison exactly one edge after the stimulus that caused it.

// File: rtl/regtimer_pkg.sv
package regtimer_pkg;

  typedef enum logic [2:0] {
    OFF_LOAD   = 3'd0,
    OFF_VALUE  = 3'd1,
    OFF_CTRL   = 3'd2,
    OFF_ICLR   = 3'd3,
    OFF_RAW    = 3'd4,
    OFF_MASKED = 3'd5,
    OFF_BGLOAD = 3'd6,
    OFF_PAD    = 3'd7
  } reg_off_e;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic [1:0] div_sel;
    logic       wide;
    logic       single;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '0;

endpackage

// File: rtl/regtimer_prescale.sv
module regtimer_prescale #(
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int PW = HI_LOG2;
  localparam logic [PW-1:0] LIM_MID = PW'((1 << MID_LOG2) - 1);
  localparam logic [PW-1:0] LIM_HI  = PW'((1 << HI_LOG2) - 1);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] limit;

  always_comb begin
    unique case (div_sel)
      2'b00:   limit = '0;
      2'b01:   limit = LIM_MID;
      default: limit = LIM_HI;
    endcase
  end

  assign tick = run && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pcnt <= '0;
    else if (!run || restart)    pcnt <= '0;
    else if (tick)               pcnt <= '0;
    else                         pcnt <= pcnt + 1'b1;
  end

  p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == '0));

endmodule

// File: rtl/regtimer_count.sv
module regtimer_count #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wide,
  input  logic              periodic,
  input  logic              single,
  input  logic              load_we,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] value,
  output logic              event_o
);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] at_zero;

  assign mask  = wide ? {DATA_W{1'b1}} : NARROW_MASK;
  assign cur   = cnt_q & mask;
  assign value = cur;
  assign event_o = tick && !load_we && (cur == DATA_W'(1));

  always_comb begin
    if (single)        at_zero = '0;
    else if (periodic) at_zero = reload & mask;
    else               at_zero = mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= NARROW_MASK;
    else if (load_we)      cnt_q <= load_val & mask;
    else if (tick) begin
      if (cur == '0)       cnt_q <= at_zero;
      else                 cnt_q <= cur - 1'b1;
    end
  end

  p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> cnt_q == ($past(load_val) & $past(mask)));

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_we) |=> $stable(cnt_q));

  p_oneshot_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (single && cur == '0 && !load_we) |=> cnt_q == '0);

  p_free_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we && cur == '0 && !single && !periodic) |=> cnt_q == $past(mask));

endmodule

// File: rtl/regtimer_irq.sv
module regtimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clear_we,
  input  logic irq_en,
  output logic raw,
  output logic masked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        raw <= 1'b0;
    else if (event_i)  raw <= 1'b1;
    else if (clear_we) raw <= 1'b0;
  end

  assign masked = raw & irq_en;

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> raw);

  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_we && !event_i) |=> !raw);

endmodule

// File: rtl/regtimer_top.sv
module regtimer_top #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int ADDR_W   = 3,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import regtimer_pkg::*;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] value;
  logic              tick;
  logic              evt;
  logic              raw;
  logic              masked;
  logic              we_load, we_ctrl, we_clr, we_bg;

  assign we_load = wr_en && (addr == OFF_LOAD);
  assign we_ctrl = wr_en && (addr == OFF_CTRL);
  assign we_clr  = wr_en && (addr == OFF_ICLR);
  assign we_bg   = wr_en && (addr == OFF_BGLOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= '0;
    end else begin
      if (we_ctrl) begin
        ctrl_q.run      <= wr_data[7];
        ctrl_q.periodic <= wr_data[6];
        ctrl_q.irq_en   <= wr_data[5];
        ctrl_q.div_sel  <= wr_data[3:2];
        ctrl_q.wide     <= wr_data[1];
        ctrl_q.single   <= wr_data[0];
      end
      if (we_load || we_bg) reload_q <= wr_data;
    end
  end

  regtimer_prescale #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run),
    .restart(we_load || we_ctrl), .div_sel(ctrl_q.div_sel), .tick(tick)
  );

  regtimer_count #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wide(ctrl_q.wide),
    .periodic(ctrl_q.periodic), .single(ctrl_q.single),
    .load_we(we_load), .load_val(wr_data), .reload(reload_q),
    .value(value), .event_o(evt)
  );

  regtimer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .event_i(evt), .clear_we(we_clr),
    .irq_en(ctrl_q.irq_en), .raw(raw), .masked(masked)
  );

  assign irq = masked;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (addr)
        OFF_LOAD, OFF_BGLOAD: rd_data = reload_q;
        OFF_VALUE:            rd_data = value;
        OFF_CTRL:             rd_data = DATA_W'({ctrl_q.run, ctrl_q.periodic, ctrl_q.irq_en,
                                                 1'b0, ctrl_q.div_sel, ctrl_q.wide, ctrl_q.single});
        OFF_RAW:              rd_data = DATA_W'(raw);
        OFF_MASKED:           rd_data = DATA_W'(masked);
        default:              rd_data = '0;
      endcase
    end
  end

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq);

  p_bg_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_bg && !tick) |=> $stable(value));

endmodule

// File: tb/tb_regtimer_top.sv
module tb_regtimer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b1;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0]  m_ctrl = 8'h00;
  logic [31:0] m_rel  = 32'h0;
  logic [31:0] m_cnt  = 32'h0000FFFF;
  logic        m_raw  = 1'b0;
  int          m_ps   = 0;

  always #4 clk = ~clk;

  regtimer_top dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd6: return m_rel;
      3'd1:       return m_cnt & (m_ctrl[1] ? 32'hFFFFFFFF : 32'h0000FFFF);
      3'd2:       return {24'h0, m_ctrl & 8'hEF};
      3'd4:       return {31'h0, m_raw};
      3'd5:       return {31'h0, m_raw & m_ctrl[5]};
      default:    return 32'h0;
    endcase
  endfunction

  // model advances on the same rising edge as the design
  always @(posedge clk) begin
    if (rst_n) begin
      logic [31:0] msk, cur;
      int div;
      bit tk, ev, wl, wc;
      msk = m_ctrl[1] ? 32'hFFFFFFFF : 32'h0000FFFF;
      div = (m_ctrl[3:2] == 2'b00) ? 1 : (m_ctrl[3:2] == 2'b01) ? 16 : 256;
      tk  = m_ctrl[7] && (m_ps == div - 1);
      wl  = wr_en && addr == 3'd0;
      wc  = wr_en && addr == 3'd2;
      cur = m_cnt & msk;
      ev  = 1'b0;
      if (wl) m_cnt = wr_data & msk;
      else if (tk) begin
        if (cur == 32'd1) begin m_cnt = 0; ev = 1'b1; end
        else if (cur == 0) m_cnt = m_ctrl[0] ? 32'h0 : m_ctrl[6] ? (m_rel & msk) : msk;
        else m_cnt = cur - 1;
      end
      if (!m_ctrl[7] || wl || wc || tk) m_ps = 0;
      else m_ps = (m_ps + 1) % 256;
      if (ev) m_raw = 1'b1;
      else if (wr_en && addr == 3'd3) m_raw = 1'b0;
      if (wc) m_ctrl = wr_data[7:0] & 8'hEF;
      if (wr_en && (addr == 3'd0 || addr == 3'd6)) m_rel = wr_data;
    end
  end

  // compare every cycle, before inputs move
  always @(negedge clk) begin
    if (running) begin
      chk(cur_req, rd_data, m_read(addr));
      chk(cur_req, {31'h0, irq}, {31'h0, m_raw & m_ctrl[5]});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [2:0] a, input int n);
    @(negedge clk); #1;
    addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      running = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    addr = 3'd2; #1 chk("R1", rd_data, 32'h0);
    addr = 3'd0; #1 chk("R1", rd_data, 32'h0);
    addr = 3'd1; #1 chk("R1", rd_data, 32'h0000FFFF);
    chk("R1", {31'h0, irq}, 32'h0);
    running = 1'b1;

    // R10: reserved bit, read-only and padding words
    cur_req = "R10";
    wr(3'd2, 32'h0000_0010);
    look(3'd2, 2);
    wr(3'd1, 32'h0000_1234);
    wr(3'd7, 32'hDEAD_BEEF);
    look(3'd1, 2); look(3'd7, 2); look(3'd3, 2);

    // R2: immediate load versus background reload
    cur_req = "R2";
    wr(3'd6, 32'h0000_0050);
    look(3'd1, 2); look(3'd0, 1);
    wr(3'd0, 32'h0000_0030);
    look(3'd1, 2); look(3'd6, 1);

    // R4: narrow mode masks the upper half
    cur_req = "R4";
    wr(3'd0, 32'h0001_2345);
    look(3'd1, 2);

    // R5: free-running wrap, narrow then wide
    cur_req = "R5";
    wr(3'd0, 32'd3);
    wr(3'd2, 32'h0000_0080);
    look(3'd1, 8);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'h0000_0082);
    look(3'd1, 6);

    // R6: periodic reload taken from the background value
    cur_req = "R6";
    wr(3'd2, 32'h0000_0040);
    wr(3'd0, 32'd4);
    wr(3'd6, 32'd2);
    wr(3'd2, 32'h0000_00E0);
    look(3'd1, 16);

    // R8: clear strobe held across events, events must win
    cur_req = "R8";
    @(negedge clk); #1; addr = 3'd3; wr_data = 32'h0; wr_en = 1'b1;
    repeat (10) @(negedge clk);
    #1 wr_en = 1'b0;
    look(3'd4, 6);

    // R9: enable cleared, raw set but masked low
    cur_req = "R9";
    wr(3'd2, 32'h0000_00C0);
    look(3'd4, 4); look(3'd5, 4);
    wr(3'd2, 32'h0000_00E0);
    look(3'd5, 6);

    // R7: one-shot stops at zero, also with periodic set
    cur_req = "R7";
    wr(3'd3, 32'h0);
    wr(3'd0, 32'd5);
    wr(3'd2, 32'h0000_00A1);
    look(3'd1, 10);
    wr(3'd3, 32'h0);
    look(3'd4, 20);
    wr(3'd0, 32'd3);
    wr(3'd2, 32'h0000_00E1);
    look(3'd1, 12);

    // R3: divider settings and disabled hold
    cur_req = "R3";
    wr(3'd0, 32'd3);
    wr(3'd2, 32'h0000_0084);
    look(3'd1, 80);
    wr(3'd2, 32'h0000_0088);
    look(3'd1, 600);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'h0000_00AC);
    look(3'd1, 800);
    wr(3'd2, 32'h0000_0000);
    look(3'd1, 20);

    finish_run();
  end
endmodule